// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block gathers 32 active-high, level-sensitive interrupt requests and spreads them over four output lines. There are two ordinary interrupt lines, one per processor core, and two machine-check lines, again one per core. Every request is first brought into the local clock domain by a two-stage synchronizer. The synchronized levels are kept as a read-only status word.

Four writable 32-bit masks pick which requests reach each output. An output is simply the OR of every request that is both active and enabled by that output's mask. The masks are independent of each other, so a single request can drive any number of outputs at once.

There is no acknowledge path. Each output follows the request levels and the mask contents directly. Software finds the source by reading the status word and ANDing it with a mask, then clears the request at its origin. A small synchronous register port gives access to the status word and the four masks.

Top module: `irq_aggregator`

## Requirements
- R1: Each request input passes through two flip-flops. A level change at `irq_in` appears in the status word, and in the outputs, after exactly two rising clock edges and not after one.
- R2: A read of byte address 0x00 returns the synchronized request levels, with request n at bit n.
- R3: The four masks sit at byte addresses 0x10 (core 0 interrupt), 0x14 (core 1 interrupt), 0x18 (core 0 machine check) and 0x1C (core 1 machine check). A read returns exactly the value last written.
- R4: While reset is held and after it is released, all four masks are zero, all four outputs are low and `reg_rdata` is zero.
- R5: `core_irq[c]` is high exactly when (status AND interrupt mask of core c) is nonzero. `core_mchk[c]` is high exactly when (status AND machine-check mask of core c) is nonzero. In both, a mask bit of 1 enables a request and 0 blocks it.
- R6: The masks are not exclusive. One request enabled in all four masks drives all four outputs high together.
- R7: No acknowledge exists. An output stays high for as long as its enabled request stays high. It drops only when the request falls (after synchronization) or when the mask bit is cleared, and in the second case it drops on the clock edge of that write.
- R8: Writes to address 0x00, to any address not listed in R3, or to any address whose low two bits are not zero are ignored. No mask and no output changes.
- R9: Reads from any address other than 0x00 and the four mask addresses, including addresses whose low two bits are not zero, return zero.
- R10: `reg_rdata` is loaded on the rising edge where `reg_rd` is high and holds its value until the next read. A mask write takes effect on the rising edge where `reg_wr` is high, so a read in the following cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 32 | Asynchronous level request inputs, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| core_irq | output | 2 | Interrupt line for each core |
| core_mchk | output | 2 | Machine-check line for each core |

## Verification
The following are checked by assertions on every cycle:
- the two-edge synchronizer latency;
- a mask taking the written value on a decoded write;
- the masks staying unchanged on an ignored write;
- zero read data for unmapped reads and status read data for status reads;
- the read data holding between reads;
- at most one register decoding at once;
- the outputs staying steady while status and masks stay steady.

Only the bench scenarios can show the rest:
- the reset state;
- the exact address map;
- the OR-of-enabled behaviour for many random patterns;
- one request fanning out to all four lines;
- an output dropping on the edge of a mask clear, or two edges after its request falls.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int SRC_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_CORE = 2;
  localparam int NUM_MASK = 2 * NUM_CORE;

  localparam logic [ADDR_W-1:0] OFS_STATUS    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IRQ_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MCHK_BASE = 8'h18;

  // Mask index k: k < NUM_CORE is the interrupt mask of core k,
  // otherwise the machine-check mask of core k - NUM_CORE.
  function automatic logic [ADDR_W-1:0] mask_offset(input int k);
    if (k < NUM_CORE)
      return OFS_IRQ_BASE + ADDR_W'(4 * k);
    else
      return OFS_MCHK_BASE + ADDR_W'(4 * (k - NUM_CORE));
  endfunction

  function automatic logic any_enabled(input logic [SRC_W-1:0] levels,
                                       input logic [SRC_W-1:0] enables);
    return |(levels & enables);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

  assign sync_out = stage2;

  // Cycles since reset, saturating, so the latency check never looks past reset.
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (sync_out == $past(async_in, 2))); // R1

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_agg_pkg::*;
#(
  parameter int W      = SRC_W,
  parameter int AW     = ADDR_W,
  parameter int NMASK  = NUM_MASK
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [W-1:0]           wdata,
  input  logic [W-1:0]           status,
  output logic [NMASK-1:0][W-1:0] masks,
  output logic [W-1:0]           rdata
);

  logic             hit_status;
  logic [NMASK-1:0] hit_mask;
  logic             hit_any;
  logic [W-1:0]     rd_mux;

  assign hit_status = (addr == AW'(OFS_STATUS));
  assign hit_any    = hit_status | (|hit_mask);

  for (genvar k = 0; k < NMASK; k++) begin : g_mask
    assign hit_mask[k] = (addr == AW'(mask_offset(k)));

    always_ff @(posedge clk) begin
      if (!rst_n)                  masks[k] <= '0;
      else if (wr_en && hit_mask[k]) masks[k] <= wdata;
    end

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_mask[k]) |=> (masks[k] == $past(wdata))); // R3
  end

  always_comb begin
    rd_mux = '0;
    if (hit_status) rd_mux = status;
    for (int k = 0; k < NMASK; k++) begin
      if (hit_mask[k]) rd_mux = masks[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_status, hit_mask})); // R3

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(|hit_mask)) |=> $stable(masks)); // R8

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_any) |=> (rdata == '0)); // R9

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_status) |=> (rdata == $past(status))); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R10

endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_agg_pkg::*;
#(
  parameter int W     = SRC_W,
  parameter int NMASK = NUM_MASK
) (
  input  logic [W-1:0]            status,
  input  logic [NMASK-1:0][W-1:0] masks,
  output logic [NMASK-1:0]        lines
);

  for (genvar k = 0; k < NMASK; k++) begin : g_line
    assign lines[k] = any_enabled(status, masks[k]);
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NSRC  = SRC_W,
  parameter int AW    = ADDR_W,
  parameter int NCORE = NUM_CORE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_in,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [NSRC-1:0]  reg_wdata,
  output logic [NSRC-1:0]  reg_rdata,
  output logic [NCORE-1:0] core_irq,
  output logic [NCORE-1:0] core_mchk
);

  localparam int NMASK = 2 * NCORE;

  logic [NSRC-1:0]             sync_status;
  logic [NMASK-1:0][NSRC-1:0]  mask_bank;
  logic [NMASK-1:0]            route_lines;

  irq_sync #(.W(NSRC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (sync_status)
  );

  irq_regs #(.W(NSRC), .AW(AW), .NMASK(NMASK)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .rd_en  (reg_rd),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .status (sync_status),
    .masks  (mask_bank),
    .rdata  (reg_rdata)
  );

  irq_route #(.W(NSRC), .NMASK(NMASK)) u_route (
    .status (sync_status),
    .masks  (mask_bank),
    .lines  (route_lines)
  );

  assign core_irq  = route_lines[NCORE-1:0];
  assign core_mchk = route_lines[NMASK-1:NCORE];

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(sync_status) && $stable(mask_bank)) |-> $stable({core_mchk, core_irq})); // R7

  AST_NO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_bank == '0) |-> ({core_mchk, core_irq} == '0)); // R5

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        reg_wr;
  logic        reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [1:0]  core_irq;
  logic [1:0]  core_mchk;

  always #10 clk = ~clk;

  irq_aggregator u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .core_irq  (core_irq),
    .core_mchk (core_mchk)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_mask [4];
  logic [31:0] m_stat;

  function automatic logic [7:0] addr_of(input int k);
    case (k)
      0: return 8'h10;
      1: return 8'h14;
      2: return 8'h18;
      default: return 8'h1C;
    endcase
  endfunction

  function automatic logic [3:0] exp_lines(input logic [31:0] st);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = ((st & m_mask[k]) != 32'd0);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_inputs(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    repeat (2) @(negedge clk);
    m_stat = v;
  endtask

  task automatic chk_lines(input string req);
    chk(req, {28'd0, core_mchk, core_irq}, {28'd0, exp_lines(m_stat)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] seed_set;
    seed_set = $urandom(32'd7319);
    rst_n = 1'b0; irq_in = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    for (int k = 0; k < 4; k++) m_mask[k] = '0;
    m_stat = '0;
    repeat (3) @(negedge clk);
    // R4: state while reset is held
    chk("R4 rdata in reset", reg_rdata, 32'd0);
    chk("R4 lines in reset", {28'd0, core_mchk, core_irq}, 32'd0);
    rst_n = 1'b1;
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    m_stat = 32'hFFFF_FFFF;
    chk("R4 lines low with masks zero", {28'd0, core_mchk, core_irq}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      do_read(addr_of(k), rd);
      chk("R4 mask reset value", rd, 32'd0);
    end

    // R1: latency of exactly two edges
    set_inputs(32'd0);
    do_write(8'h10, 32'h0000_0100);
    m_mask[0] = 32'h0000_0100;
    @(negedge clk); irq_in = 32'h0000_0100;
    @(negedge clk);
    chk("R1 not after one edge", {31'd0, core_irq[0]}, 32'd0);
    @(negedge clk);
    chk("R1 after two edges", {31'd0, core_irq[0]}, 32'd1);
    m_stat = 32'h0000_0100;

    // R2: status readback
    set_inputs(32'hA5C3_0F96);
    do_read(8'h00, rd);
    chk("R2 status read", rd, 32'hA5C3_0F96);

    // R3: address map readback
    for (int k = 0; k < 4; k++) begin
      m_mask[k] = $urandom;
      do_write(addr_of(k), m_mask[k]);
    end
    for (int k = 0; k < 4; k++) begin
      do_read(addr_of(k), rd);
      chk("R3 mask readback", rd, m_mask[k]);
    end
    chk_lines("R5 directed");

    // R6: one request reaches all four lines
    for (int k = 0; k < 4; k++) begin
      m_mask[k] = 32'h8000_0000;
      do_write(addr_of(k), m_mask[k]);
    end
    set_inputs(32'h8000_0000);
    chk("R6 fan-out to all four", {28'd0, core_mchk, core_irq}, 32'hF);

    // R7: level held, no acknowledge, drops on input fall
    repeat (5) @(negedge clk);
    chk("R7 still high without ack", {28'd0, core_mchk, core_irq}, 32'hF);
    set_inputs(32'd0);
    chk("R7 drops after input falls", {28'd0, core_mchk, core_irq}, 32'h0);
    set_inputs(32'h8000_0000);
    // R7 / R10: mask clear drops the line on the edge of the write
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h14; reg_wdata = 32'd0;
    @(negedge clk);
    reg_wr = 0;
    m_mask[1] = 32'd0;
    chk("R7 drop on mask clear edge", {28'd0, core_mchk, core_irq}, 32'hD);
    do_read(8'h14, rd);
    chk("R10 read after write", rd, 32'd0);

    // R8: ignored writes
    do_write(8'h00, 32'hFFFF_FFFF);
    do_write(8'h20, 32'hFFFF_FFFF);
    do_write(8'h11, 32'hFFFF_FFFF);
    do_write(8'h04, 32'hFFFF_FFFF);
    chk_lines("R8 lines unchanged");
    for (int k = 0; k < 4; k++) begin
      do_read(addr_of(k), rd);
      chk("R8 mask unchanged", rd, m_mask[k]);
    end
    do_read(8'h00, rd);
    chk("R8 status not writable", rd, m_stat);

    // R9: unmapped reads
    do_read(8'h04, rd);  chk("R9 read 0x04", rd, 32'd0);
    do_read(8'h20, rd);  chk("R9 read 0x20", rd, 32'd0);
    do_read(8'h12, rd);  chk("R9 read misaligned", rd, 32'd0);
    do_read(8'hFC, rd);  chk("R9 read 0xFC", rd, 32'd0);

    // R10: read data holds between reads
    do_read(8'h00, rd);
    repeat (4) @(negedge clk);
    irq_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    m_stat = 32'h1234_5678;
    chk("R10 rdata holds", reg_rdata, 32'h8000_0000);

    // R5: random patterns
    for (int i = 0; i < 60; i++) begin
      int k;
      k = int'($urandom_range(0, 3));
      m_mask[k] = $urandom & $urandom;
      do_write(addr_of(k), m_mask[k]);
      set_inputs($urandom & $urandom);
      chk_lines("R5 random");
      if (i % 6 == 0) begin
        do_read(8'h00, rd);
        chk("R2 random status", rd, m_stat);
        do_read(addr_of(k), rd);
        chk("R3 random readback", rd, m_mask[k]);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule